// File: doc/BRIEF.md
# Stream Index Global Predictor

This block is a second-stage compressor for a trace of stream-cache indices. Every accepted index is compared with a prediction read from a table, and the table is addressed by the index that came before it. A correct prediction costs one bit in the output trace. A wrong prediction costs one bit plus the full index on a separate miss channel, and the table entry is then rewritten with the index that actually arrived. The index always moves into the history afterwards, whether the prediction was right or wrong.

The prediction bits are collected into bytes, most significant bit first. An external flush request pushes out a byte that is only partly filled and states how many of its bits are valid. After reset the block clears the table by writing zeros to one entry per cycle. During that sweep it refuses input. Once the sweep is done it takes one index per clock, with no gaps.

The control state machine has two states. ST_CLEAR sweeps the table. The transition ST_CLEAR to ST_RUN is taken on the cycle the last entry is written. ST_RUN accepts indices and stays in that state until reset.

Top module: `sidx_gpred`

## Requirements
- R1: For the 2^TBL_AW cycles after reset is released (256 by default), in_ready is low, in_valid is ignored and mt_valid stays low. in_ready rises on the clock edge that writes the last table entry.
- R2: The table address is the previously accepted index. With the default history length of 1 this address is that index itself. After reset the history and every table entry are 0.
- R3: When the addressed entry equals in_idx, a 1 is recorded in the prediction trace and mt_valid stays low.
- R4: When the addressed entry differs from in_idx, a 0 is recorded, and in the cycle after acceptance mt_valid is high and mt_idx carries in_idx. The entry is overwritten with in_idx, and the next read of that entry sees the new value.
- R5: Every accepted index enters the history, on a hit and on a miss alike.
- R6: Prediction bits fill pb_data from bit 7 downward. In the cycle after the eighth bit is accepted, pb_valid is high and pb_nbits is 8.
- R7: A flush with k pending bits (k from 1 to 7) emits them in the top k positions of pb_data. The lower bits are zero, pb_nbits is k, and the next bit starts a fresh byte.
- R8: A flush with no pending bits emits nothing.
- R9: When a flush and an accepted index fall in the same cycle, the new bit goes into the byte before it is flushed.
- R10: Once high, in_ready stays high, and indices offered on consecutive cycles are all accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Index offered |
| in_ready | output | 1 | Index can be accepted |
| in_idx | input | IDX_W | Incoming stream-cache index |
| flush | input | 1 | Emit any partly filled prediction byte |
| pb_valid | output | 1 | Prediction byte valid |
| pb_data | output | PK_W | Prediction bits, MSB first |
| pb_nbits | output | $clog2(PK_W+1) | Number of valid bits in pb_data |
| mt_valid | output | 1 | Miss-trace index valid |
| mt_idx | output | IDX_W | Index that was mispredicted |

## Verification
Two things can happen in the same cycle here, and the bench drives both. The first is a flush together with an accepted index. The bench checks that the emitted byte contains the new bit and that pb_nbits counts it. The second is a miss write-back immediately followed by a read of the same entry. The bench offers one index twice in a row, so the second lookup must hit on the value written one edge earlier. All expected bytes and miss indices come from a vector table worked out by hand, and then from a reference model driven by a long patterned sequence.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } sgp_state_e;
endpackage

// File: rtl/sgp_history.sv
module sgp_history #(
    parameter int IDX_W    = 8,
    parameter int TBL_AW   = 8,
    parameter int HIST_LEN = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [IDX_W-1:0]  idx_in,
    output logic [TBL_AW-1:0] tbl_addr
);
    logic [IDX_W-1:0] hist_q [HIST_LEN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < HIST_LEN; i++) hist_q[i] <= '0;
        end else if (push) begin
            hist_q[0] <= idx_in;
            for (int i = 1; i < HIST_LEN; i++) hist_q[i] <= hist_q[i-1];
        end
    end

    // Fold all history entries into one table address.
    always_comb begin
        tbl_addr = '0;
        for (int i = 0; i < HIST_LEN; i++) tbl_addr = tbl_addr ^ hist_q[i][TBL_AW-1:0];
    end
endmodule

// File: rtl/sgp_table.sv
module sgp_table #(
    parameter int IDX_W  = 8,
    parameter int TBL_AW = 8
) (
    input  logic              clk,
    input  logic [TBL_AW-1:0] rd_addr,
    output logic [IDX_W-1:0]  rd_data,
    input  logic              wr_en,
    input  logic [TBL_AW-1:0] wr_addr,
    input  logic [IDX_W-1:0]  wr_data
);
    localparam int DEPTH = 1 << TBL_AW;

    logic [IDX_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/sgp_packer.sv
module sgp_packer #(
    parameter int PK_W = 8,
    localparam int CW  = $clog2(PK_W + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_valid,
    input  logic            bit_in,
    input  logic            flush,
    output logic            pb_valid,
    output logic [PK_W-1:0] pb_data,
    output logic [CW-1:0]   pb_nbits
);
    logic [PK_W-1:0] acc_q, acc_n;
    logic [CW-1:0]   cnt_q, cnt_n;
    logic            emit;

    always_comb begin
        acc_n = acc_q;
        cnt_n = cnt_q;
        if (bit_valid) begin
            for (int b = 0; b < PK_W; b++) begin
                if (b == PK_W - 1 - int'(cnt_q)) acc_n[b] = bit_in;
            end
            cnt_n = cnt_q + CW'(1);
        end
        emit = (cnt_n == CW'(PK_W)) || (flush && (cnt_n != '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            pb_valid <= 1'b0;
            pb_data  <= '0;
            pb_nbits <= '0;
        end else begin
            pb_valid <= emit;
            if (emit) begin
                pb_data  <= acc_n;
                pb_nbits <= cnt_n;
                acc_q    <= '0;
                cnt_q    <= '0;
            end else begin
                acc_q <= acc_n;
                cnt_q <= cnt_n;
            end
        end
    end
endmodule

// File: rtl/sidx_gpred.sv
module sidx_gpred
    import sgp_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int TBL_AW   = 8,
    parameter int HIST_LEN = 1,
    parameter int PK_W     = 8,
    localparam int NB_W    = $clog2(PK_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IDX_W-1:0] in_idx,
    input  logic             flush,
    output logic             pb_valid,
    output logic [PK_W-1:0]  pb_data,
    output logic [NB_W-1:0]  pb_nbits,
    output logic             mt_valid,
    output logic [IDX_W-1:0] mt_idx
);
    localparam logic [TBL_AW-1:0] CLR_LAST = '1;

    sgp_state_e        state_q, state_n;
    logic [TBL_AW-1:0] clr_q;
    logic              accept, hit;
    logic [TBL_AW-1:0] pred_addr;
    logic [IDX_W-1:0]  pred_idx;
    logic              tbl_we;
    logic [TBL_AW-1:0] tbl_wa;
    logic [IDX_W-1:0]  tbl_wd;

    // State register and clear sweep counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            clr_q   <= '0;
        end else begin
            state_q <= state_n;
            if (state_q == ST_CLEAR) clr_q <= clr_q + TBL_AW'(1);
        end
    end

    // Next state and outputs.
    always_comb begin
        state_n  = state_q;
        in_ready = 1'b0;
        tbl_we   = 1'b0;
        tbl_wa   = pred_addr;
        tbl_wd   = in_idx;
        unique case (state_q)
            ST_CLEAR: begin
                tbl_we = 1'b1;
                tbl_wa = clr_q;
                tbl_wd = '0;
                if (clr_q == CLR_LAST) state_n = ST_RUN;
            end
            ST_RUN: begin
                in_ready = 1'b1;
                tbl_we   = in_valid && (pred_idx != in_idx);
            end
            default: state_n = ST_CLEAR;
        endcase
    end

    assign accept = in_valid && in_ready;
    assign hit    = (pred_idx == in_idx);

    sgp_history #(.IDX_W(IDX_W), .TBL_AW(TBL_AW), .HIST_LEN(HIST_LEN)) u_hist (
        .clk(clk), .rst_n(rst_n), .push(accept), .idx_in(in_idx), .tbl_addr(pred_addr)
    );

    sgp_table #(.IDX_W(IDX_W), .TBL_AW(TBL_AW)) u_tbl (
        .clk(clk), .rd_addr(pred_addr), .rd_data(pred_idx),
        .wr_en(tbl_we), .wr_addr(tbl_wa), .wr_data(tbl_wd)
    );

    sgp_packer #(.PK_W(PK_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .bit_valid(accept), .bit_in(hit), .flush(flush),
        .pb_valid(pb_valid), .pb_data(pb_data), .pb_nbits(pb_nbits)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mt_valid <= 1'b0;
            mt_idx   <= '0;
        end else begin
            mt_valid <= accept && !hit;
            if (accept && !hit) mt_idx <= in_idx;
        end
    end
endmodule

// File: rtl/sgp_checker.sv
module sgp_checker #(
    parameter int PK_W = 8,
    localparam int NB_W = $clog2(PK_W + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            flush,
    input logic            pb_valid,
    input logic [PK_W-1:0] pb_data,
    input logic [NB_W-1:0] pb_nbits,
    input logic            mt_valid
);
    localparam logic [PK_W-1:0] ONES = '1;

    AST_MISS_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        mt_valid |-> $past(in_valid && in_ready)); // R4
    AST_NO_MISS_WHILE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> !mt_valid); // R1
    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> in_ready); // R10
    AST_NBITS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pb_valid |-> (pb_nbits != '0 && pb_nbits <= NB_W'(PK_W))); // R6
    AST_PARTIAL_NEEDS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_valid && pb_nbits != NB_W'(PK_W)) |-> $past(flush)); // R7
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pb_valid |-> ((pb_data & (ONES >> pb_nbits)) == '0)); // R7
endmodule

bind sidx_gpred sgp_checker #(.PK_W(PK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .flush(flush),
    .pb_valid(pb_valid), .pb_data(pb_data), .pb_nbits(pb_nbits), .mt_valid(mt_valid)
);

// File: tb/sidx_gpred_tb.sv
`timescale 1ns/1ps
module sidx_gpred_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_idx = '0;
    logic       flush = 1'b0;
    logic       in_ready, pb_valid, mt_valid;
    logic [7:0] pb_data, mt_idx;
    logic [3:0] pb_nbits;

    int errors = 0;
    int checks = 0;

    // reference state
    logic [7:0] mtab [256];
    logic [7:0] mhist;
    logic [7:0] macc;
    int         mcnt;

    always #5 clk = ~clk;

    sidx_gpred u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx),
        .flush(flush), .pb_valid(pb_valid), .pb_data(pb_data), .pb_nbits(pb_nbits),
        .mt_valid(mt_valid), .mt_idx(mt_idx)
    );

    // {flush, expected hit, index}; hits and misses worked out by hand from an empty table
    localparam logic [9:0] VEC [13] = '{
        {1'b0, 1'b0, 8'd5}, {1'b0, 1'b0, 8'd7}, {1'b0, 1'b0, 8'd5}, {1'b0, 1'b1, 8'd7},
        {1'b0, 1'b1, 8'd5}, {1'b0, 1'b1, 8'd7}, {1'b0, 1'b0, 8'd0}, {1'b0, 1'b1, 8'd5},
        {1'b0, 1'b1, 8'd7}, {1'b0, 1'b1, 8'd0}, {1'b0, 1'b0, 8'd9}, {1'b0, 1'b0, 8'd9},
        {1'b1, 1'b1, 8'd9}
    };

    task automatic chk(input logic ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Called at a negedge; drives one cycle and checks outputs at the next negedge.
    task automatic step(input logic v, input logic [7:0] idx, input logic fl,
                        input logic hit, input string rq);
        logic emit;
        in_valid = v; in_idx = idx; flush = fl;
        @(negedge clk);
        if (v) begin
            chk(mt_valid == !hit, rq, mt_valid, !hit);
            if (!hit) chk(mt_idx == idx, {rq, " R4 idx"}, mt_idx, idx);
            if (!hit) mtab[mhist] = idx;
            mhist = idx;
            macc[7 - mcnt] = hit;
            mcnt++;
        end else begin
            chk(mt_valid == 1'b0, {rq, " idle miss"}, mt_valid, 0);
        end
        emit = (mcnt == 8) || (fl && mcnt != 0);
        chk(pb_valid == emit, {rq, " R6 pb_valid"}, pb_valid, emit);
        if (emit) begin
            chk(pb_data == macc, {rq, " R6 pb_data"}, pb_data, macc);
            chk(int'(pb_nbits) == mcnt, {rq, " R7 pb_nbits"}, pb_nbits, mcnt);
            macc = '0; mcnt = 0;
        end
        in_valid = 1'b0; flush = 1'b0;
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        logic [7:0] pat [6];
        logic [15:0] lfsr;
        for (int i = 0; i < 256; i++) mtab[i] = '0;
        mhist = '0; macc = '0; mcnt = 0;
        pat = '{8'd3, 8'd40, 8'd3, 8'd77, 8'd200, 8'd40};

        // reset state
        repeat (3) @(negedge clk);
        chk(in_ready == 0 && pb_valid == 0 && mt_valid == 0, "R1 reset outputs",
            {in_ready, pb_valid, mt_valid}, 0);
        rst_n = 1'b1;

        // R1: clear sweep, offered input ignored
        n = 0;
        in_valid = 1'b1; in_idx = 8'd3;
        while (!in_ready && n < 400) begin
            @(negedge clk);
            n++;
            if (mt_valid) chk(1'b0, "R1 miss during clear", 1, 0);
        end
        in_valid = 1'b0;
        chk(n == 256, "R1 clear length", n, 256);
        chk(pb_valid == 0 && mt_valid == 0, "R1 no output after clear", pb_valid, 0);

        // vector table: R2 R3 R4 R5 R6, back to back (R10)
        for (int i = 0; i < 11; i++)
            step(1'b1, VEC[i][7:0], VEC[i][9], VEC[i][8], $sformatf("R3/R4 vec%0d", i));
        chk(in_ready == 1'b1, "R10 ready after burst", in_ready, 1);

        // R7: flush of 3 pending bits -> 110 padded
        step(1'b0, 8'd0, 1'b1, 1'b0, "R7 partial flush");
        // R4 write-back then immediate read of same entry; R9 flush with bit
        step(1'b1, VEC[11][7:0], VEC[11][9], VEC[11][8], "R4 self repeat miss");
        step(1'b1, VEC[12][7:0], VEC[12][9], VEC[12][8], "R9 flush with bit");
        // R8: flush with nothing pending
        step(1'b0, 8'd0, 1'b1, 1'b0, "R8 empty flush");
        step(1'b0, 8'd0, 1'b0, 1'b0, "R8 idle");

        // patterned run against the reference model (R2 R3 R4 R5 R6 R10)
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            logic [7:0] x;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            x = (lfsr[3:0] == 4'h0) ? lfsr[15:8] : pat[i % 6];
            step(1'b1, x, (i % 37) == 36, mtab[mhist] == x, "R5 model run");
        end
        step(1'b0, 8'd0, 1'b1, 1'b0, "R7 final flush");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule